// File: doc/BRIEF.md
# RV32I Integer ALU with Built-In Field Decode

This block is the execute-stage arithmetic-logic unit of a 32-bit RISC-V integer pipeline. It is purely combinational. It takes the raw instruction fields straight from the instruction word: the 7-bit major opcode, the 3-bit funct3, and the one funct7 bit that tells add from subtract and logical from arithmetic right shift. From these it derives its operation, applies it to two 32-bit operands and returns a 32-bit result. No separate ALU-control encoding sits in front of it.

The unit covers register-register and register-immediate arithmetic, logic, shift and set-less-than operations. It also handles the two upper-immediate forms. Load-upper passes operand B through unchanged. Add-upper-to-PC adds the program counter, carried on operand A, to B. Branch conditions are not evaluated here; a separate comparator does that. Branch, jump, load and store opcodes, and any opcode not listed below, produce zero. Immediate generation and register access happen upstream.

Inside, a field decoder names one internal operation from a fixed set. A shared adder serves add, subtract and both comparisons. A logarithmic shifter serves all three shifts. A final selector picks the result.

Top module: `rv_int_alu`

## Requirements
- R1: With opcode 0110011 and funct3 000, the result is A+B when the modifier bit is 0 and A−B when it is 1, both wrapping modulo 2^32.
- R2: With opcode 0010011, the modifier bit is ignored for every funct3 except 101; in particular funct3 000 always gives A+B.
- R3: funct3 010 (either arithmetic opcode) gives 1 when A is less than B as two's-complement numbers and 0 otherwise, in bit 0, with bits 31:1 zero.
- R4: funct3 011 (either arithmetic opcode) gives the same 1/0 result for an unsigned comparison.
- R5: funct3 100, 110 and 111 give bitwise XOR, OR and AND of A and B.
- R6: funct3 001 gives A shifted left by B[4:0], zero-filled; the upper bits of B have no effect.
- R7: funct3 101 gives a right shift of A by B[4:0]; with the modifier bit at 1 the vacated bits copy A[31], with it at 0 they are zero.
- R8: Opcode 0110111 gives B unchanged.
- R9: Opcode 0010111 gives A+B modulo 2^32.
- R10: Every other opcode, including branch 1100011, jal 1101111, jalr 1100111, load 0000011 and store 0100011, gives 0.
- R11: With opcode 0110011, the modifier bit has no effect for funct3 values other than 000 and 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Major opcode field of the instruction |
| funct3_i | input | 3 | funct3 field of the instruction |
| alt_i | input | 1 | funct7 modifier bit (subtract / arithmetic shift) |
| a_i | input | 32 | First operand (register value or PC) |
| b_i | input | 32 | Second operand (register value or immediate) |
| result_o | output | 32 | Computed result |

## Verification
The unit has no state, so a wrong decode shows at result_o in the same evaluation as the input change that caused it. An operation selected wrongly shows as a mismatch against the independently computed expected value. Typical cases are a modifier bit that is honoured where it should be ignored, a compare that is signed where it should be unsigned, or a shift that reads too many bits of B. The directed cases target the operand patterns where such errors differ from the correct result: sign-bit operands, all-ones wraparound, and shift amounts with bits set above bit 4.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

    localparam int unsigned OPC_W = 7;
    localparam int unsigned F3_W  = 3;

    localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LUI   = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC = 7'b0010111;

    localparam logic [F3_W-1:0] F3_ADD  = 3'b000;
    localparam logic [F3_W-1:0] F3_SLL  = 3'b001;
    localparam logic [F3_W-1:0] F3_SLT  = 3'b010;
    localparam logic [F3_W-1:0] F3_SLTU = 3'b011;
    localparam logic [F3_W-1:0] F3_XOR  = 3'b100;
    localparam logic [F3_W-1:0] F3_SHR  = 3'b101;
    localparam logic [F3_W-1:0] F3_OR   = 3'b110;
    localparam logic [F3_W-1:0] F3_AND  = 3'b111;

    typedef enum logic [3:0] {
        OP_ZERO,
        OP_ADD,
        OP_SUB,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND,
        OP_PASSB
    } alu_op_e;

endpackage

// File: rtl/rv_alu_decode.sv
module rv_alu_decode
    import rv_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [F3_W-1:0]  funct3_i,
    input  logic             alt_i,
    output alu_op_e          op_o
);

    alu_op_e arith_op;

    // Operation named by funct3 for the two arithmetic opcode groups.
    always_comb begin
        arith_op = OP_ZERO;
        unique case (funct3_i)
            F3_ADD:  arith_op = (alt_i && opcode_i == OPC_REG) ? OP_SUB : OP_ADD;
            F3_SLL:  arith_op = OP_SLL;
            F3_SLT:  arith_op = OP_SLT;
            F3_SLTU: arith_op = OP_SLTU;
            F3_XOR:  arith_op = OP_XOR;
            F3_SHR:  arith_op = alt_i ? OP_SRA : OP_SRL;
            F3_OR:   arith_op = OP_OR;
            F3_AND:  arith_op = OP_AND;
            default: arith_op = OP_ZERO;
        endcase
    end

    always_comb begin
        unique case (opcode_i)
            OPC_REG, OPC_IMM: op_o = arith_op;
            OPC_LUI:          op_o = OP_PASSB;
            OPC_AUIPC:        op_o = OP_ADD;
            default:          op_o = OP_ZERO;
        endcase
    end

    // Register-immediate form never subtracts (R2).
    always_comb begin
        if (opcode_i == OPC_IMM)
            p_imm_no_sub_r2: assert (op_o != OP_SUB)
                else $error("immediate form decoded to subtract");
    end

endmodule

// File: rtl/rv_alu_addcmp.sv
module rv_alu_addcmp #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            lt_signed_o,
    output logic            lt_unsigned_o
);

    localparam int unsigned MSB = XLEN - 1;

    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   wide_sum;

    // One adder serves add, subtract and both compares.
    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
        sum_o    = wide_sum[XLEN-1:0];
        // When subtracting, no carry-out means A < B (unsigned).
        lt_unsigned_o = ~wide_sum[XLEN];
        lt_signed_o   = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : wide_sum[MSB];
    end

    // Differing sign bits decide the signed compare outright (R3).
    always_comb begin
        if (sub_i && (a_i[MSB] != b_i[MSB]))
            p_sign_split_r3: assert (lt_signed_o == a_i[MSB])
                else $error("signed compare wrong for split signs");
    end

endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]         data_i,
    input  logic [$clog2(XLEN)-1:0] amt_i,
    input  logic                    left_i,
    input  logic                    arith_i,
    output logic [XLEN-1:0]         data_o
);

    localparam int unsigned STAGES = $clog2(XLEN);

    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] pre;
    logic            fill;
    logic [XLEN-1:0] stage [STAGES+1];
    logic [XLEN-1:0] rev_out;

    // A left shift is a right shift of the bit-reversed word.
    generate
        for (genvar i = 0; i < XLEN; i++) begin : g_rev
            assign rev_in[i]  = data_i[XLEN-1-i];
            assign rev_out[i] = stage[STAGES][XLEN-1-i];
        end
    endgenerate

    assign pre      = left_i ? rev_in : data_i;
    assign fill     = arith_i & ~left_i & data_i[XLEN-1];
    assign stage[0] = pre;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            localparam int unsigned DIST = 1 << s;
            assign stage[s+1] = amt_i[s]
                ? {{DIST{fill}}, stage[s][XLEN-1:DIST]}
                : stage[s];
        end
    endgenerate

    assign data_o = left_i ? rev_out : stage[STAGES];

    // Zero shift amount leaves the word untouched (R6, R7).
    always_comb begin
        if (amt_i == '0)
            p_zero_shift_r7: assert (data_o == data_i)
                else $error("zero-distance shift altered data");
    end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import rv_alu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [6:0]      opcode_i,
    input  logic [2:0]      funct3_i,
    input  logic            alt_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] result_o
);

    localparam int unsigned SHW = $clog2(XLEN);

    alu_op_e         op;
    logic            use_sub;
    logic [XLEN-1:0] sum;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] shifted;

    rv_alu_decode u_decode (
        .opcode_i (opcode_i),
        .funct3_i (funct3_i),
        .alt_i    (alt_i),
        .op_o     (op)
    );

    assign use_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

    rv_alu_addcmp #(.XLEN(XLEN)) u_addcmp (
        .a_i           (a_i),
        .b_i           (b_i),
        .sub_i         (use_sub),
        .sum_o         (sum),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u)
    );

    rv_alu_shifter #(.XLEN(XLEN)) u_shift (
        .data_i  (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (op == OP_SLL),
        .arith_i (op == OP_SRA),
        .data_o  (shifted)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:     result_o = sum;
            OP_SLT:             result_o = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU:            result_o = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:             result_o = a_i ^ b_i;
            OP_OR:              result_o = a_i | b_i;
            OP_AND:             result_o = a_i & b_i;
            OP_SLL, OP_SRL,
            OP_SRA:             result_o = shifted;
            OP_PASSB:           result_o = b_i;
            default:            result_o = '0;
        endcase
    end

    // Port-level checks across decoder, adder and shifter.
    always_comb begin
        if (opcode_i != OPC_REG && opcode_i != OPC_IMM &&
            opcode_i != OPC_LUI && opcode_i != OPC_AUIPC)
            p_other_opcode_zero_r10: assert (result_o == '0)
                else $error("unlisted opcode gave nonzero result");
        if (opcode_i == OPC_LUI)
            p_lui_pass_r8: assert (result_o == b_i)
                else $error("load-upper did not pass B");
        if ((opcode_i == OPC_REG || opcode_i == OPC_IMM) &&
            (funct3_i == F3_SLT || funct3_i == F3_SLTU))
            p_cmp_one_bit_r3: assert (result_o[XLEN-1:1] == '0)
                else $error("compare result wider than one bit");
        if ((opcode_i == OPC_REG || opcode_i == OPC_IMM) &&
            funct3_i == F3_SHR && alt_i && a_i[XLEN-1] && b_i[SHW-1:0] != '0)
            p_sra_fill_r7: assert (result_o[XLEN-1])
                else $error("arithmetic shift lost the sign");
    end

endmodule

// File: tb/rv_int_alu_tb.sv
module rv_int_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 32'h5EED_1234;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic [6:0]  opcode;
    logic [2:0]  funct3;
    logic        alt;
    logic [31:0] a, b;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv_int_alu dut_i (
        .opcode_i (opcode),
        .funct3_i (funct3),
        .alt_i    (alt),
        .a_i      (a),
        .b_i      (b),
        .result_o (result)
    );

    function automatic logic [31:0] model(input logic [6:0] o, input logic [2:0] f,
                                          input logic m, input logic [31:0] x,
                                          input logic [31:0] y);
        logic is_reg;
        is_reg = (o == 7'b0110011);
        if (o == 7'b0110111) return y;
        if (o == 7'b0010111) return x + y;
        if (o != 7'b0110011 && o != 7'b0010011) return 32'h0;
        case (f)
            3'b000: return (is_reg && m) ? x - y : x + y;
            3'b001: return x << y[4:0];
            3'b010: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            3'b011: return (x < y) ? 32'd1 : 32'd0;
            3'b100: return x ^ y;
            3'b101: return m ? 32'($signed(x) >>> y[4:0]) : x >> y[4:0];
            3'b110: return x | y;
            default: return x & y;
        endcase
    endfunction

    function automatic string tag_of(input logic [6:0] o, input logic [2:0] f,
                                     input logic m);
        if (o == 7'b0110111) return "R8";
        if (o == 7'b0010111) return "R9";
        if (o != 7'b0110011 && o != 7'b0010011) return "R10";
        if (o == 7'b0110011 && m && f != 3'b000 && f != 3'b101) return "R11";
        case (f)
            3'b000: return (o == 7'b0010011) ? "R2" : "R1";
            3'b001: return "R6";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b101: return "R7";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(input logic [6:0] o, input logic [2:0] f, input logic m,
                         input logic [31:0] x, input logic [31:0] y);
        logic [31:0] exp;
        @(negedge clk);
        opcode = o; funct3 = f; alt = m; a = x; b = y;
        #1;
        exp = model(o, f, m, x, y);
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b f3=%b m=%b a=%h b=%h actual=%h expected=%h",
                     tag_of(o, f, m), o, f, m, x, y, result, exp);
        end
    endtask

    initial begin
        opcode = '0; funct3 = '0; alt = 1'b0; a = '0; b = '0;
        // Initial state: all-zero inputs -> 0 (R10).
        apply(7'h00, 3'b000, 1'b0, 32'h0, 32'h0);
        // R1 wrap and subtract
        apply(7'b0110011, 3'b000, 1'b0, 32'hFFFF_FFFF, 32'h1);
        apply(7'b0110011, 3'b000, 1'b1, 32'h0, 32'h1);
        // R2 modifier ignored for immediate add
        apply(7'b0010011, 3'b000, 1'b1, 32'h10, 32'h3);
        apply(7'b0010011, 3'b011, 1'b1, 32'h1, 32'h2);
        // R3 / R4 sign-bit corners
        apply(7'b0110011, 3'b010, 1'b0, 32'h8000_0000, 32'h1);
        apply(7'b0110011, 3'b011, 1'b0, 32'h8000_0000, 32'h1);
        apply(7'b0010011, 3'b010, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply(7'b0110011, 3'b010, 1'b0, 32'h5, 32'h5);
        // R5
        apply(7'b0110011, 3'b100, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF);
        apply(7'b0110011, 3'b110, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF);
        apply(7'b0110011, 3'b111, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF);
        // R6 upper shift bits ignored
        apply(7'b0110011, 3'b001, 1'b0, 32'h8000_0001, 32'h21);
        // R7 arithmetic vs logical
        apply(7'b0110011, 3'b101, 1'b1, 32'h8000_0000, 32'h1F);
        apply(7'b0110011, 3'b101, 1'b0, 32'h8000_0000, 32'h1F);
        apply(7'b0010011, 3'b101, 1'b1, 32'h8000_00F0, 32'hFFFF_FFE4);
        // R8, R9
        apply(7'b0110111, 3'b011, 1'b1, 32'h1234_5678, 32'hABCD_E000);
        apply(7'b0010111, 3'b000, 1'b1, 32'hFFFF_F000, 32'h0000_2000);
        // R10 other opcodes
        apply(7'b1100011, 3'b000, 1'b0, 32'h5, 32'h5);
        apply(7'b1101111, 3'b000, 1'b0, 32'h5, 32'h5);
        apply(7'b1100111, 3'b000, 1'b0, 32'h5, 32'h5);
        apply(7'b0000011, 3'b010, 1'b0, 32'h5, 32'h5);
        apply(7'b0100011, 3'b010, 1'b0, 32'h5, 32'h5);
        // R11 modifier ignored on other register forms
        apply(7'b0110011, 3'b111, 1'b1, 32'hFF00, 32'h0FF0);
        apply(7'b0110011, 3'b001, 1'b1, 32'h1, 32'h4);

        void'($urandom(SEED));
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [6:0] o;
            logic [31:0] x, y;
            int pick;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0, 1, 2: o = 7'b0110011;
                3, 4:    o = 7'b0010011;
                5:       o = 7'b0110111;
                6:       o = 7'b0010111;
                default: o = 7'($urandom);
            endcase
            x = $urandom;
            y = $urandom;
            if ($urandom_range(0, 7) == 0) x = {x[31], 31'h0};
            if ($urandom_range(0, 7) == 0) y = 32'hFFFF_FFFF;
            apply(o, 3'($urandom), 1'($urandom), x, y);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule